// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block gathers event pulses from three timer/counters into an 8-bit pending-flag register. Beside it sits an 8-bit enable register with the same bit layout. Each source drives its own request line. A request is high only while the source's pending flag, its enable bit and a global interrupt enable are all set.

A pending flag clears in one of two ways. The interrupt controller can acknowledge the source's vector, or the processor can write a one to the flag's bit position. Writing a zero to a flag position leaves that flag as it is. A write to the enable register stores the written byte. A read returns either register in the same cycle, and a read never alters a flag.

Two of the sources belong to a timer that runs on its own clock. Their pulses cross into the processor clock through a toggle synchronizer, so that a pulse one timer cycle long is never lost. The timers generate the pulses themselves. That includes the overflow pulse that an up/down PWM timer issues when it turns around at zero.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset the pending register, the enable register and every request line read zero.
- R2: Bit positions are shared by both registers. Bits 7 and 6 are the async timer's compare and overflow, driven by `tev_i[1]` and `tev_i[0]`. Bits 5..0 are timer1 capture, timer1 compare A, timer1 compare B, timer1 overflow, timer0 compare and timer0 overflow, driven by `sev_i[5:0]` at the same positions.
- R3: `irq_o[i]` is high exactly when pending bit i, enable bit i and `gie_i` are all one.
- R4: A write with `wr_sel_i`=1 clears each pending bit whose data bit is one. Pending bits whose data bit is zero are unchanged.
- R5: `ack_i[i]` high for one cycle clears pending bit i at the next clock edge.
- R6: When a set pulse and a clear (by acknowledge or by write-one) reach the same pending bit in the same cycle, the bit ends up set.
- R7: A write with `wr_sel_i`=0 loads all eight enable bits from `wr_data_i`.
- R8: `rd_data_o` shows the enable register when `rd_sel_i`=0 and the pending register when it is 1, in the same cycle, with no effect on either register.
- R9: An async timer pulse, captured on a `tclk` rising edge, sets its pending bit on the third `clk` rising edge after that edge. The bit is still clear after the second.
- R10: Successive async pulses on the same source each set the pending bit again, so no pulse is dropped after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| tclk | input | 1 | Clock of the asynchronous timer |
| tev_i | input | 2 | Async timer pulses in the `tclk` domain: [1] compare, [0] overflow |
| sev_i | input | 6 | Synchronous timer pulses, one cycle each, bit i sets pending bit i |
| ack_i | input | 8 | Per-source vector acknowledge, clears the matching pending bit |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable register, 1 pending register (write-one-to-clear) |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 enable register, 1 pending register |
| rd_data_o | output | 8 | Selected register contents |
| irq_o | output | 8 | Per-source interrupt request |

## Verification
The assertions assume that every `sev_i` and `ack_i` pulse lasts one `clk` cycle. They also assume that async pulses on one source are far enough apart in `clk` time for each toggle to settle through the two synchronizer flops before the next one arrives. The stimulus drives all synchronous inputs at the falling `clk` edge. It pulses `tclk` only in the low half of a `clk` period and leaves at least four `clk` edges between async pulses. The set-wins property is driven in directed vectors where a pulse and an acknowledge, or a pulse and a write-one, hit one bit together.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    localparam int NSRC   = 8;
    localparam int NASYNC = 2;
    localparam int NSYNC  = NSRC - NASYNC;
    localparam int SYNC_STAGES = 2;

    localparam int B_T0_OVF  = 0;
    localparam int B_T0_CMP  = 1;
    localparam int B_T1_OVF  = 2;
    localparam int B_T1_CMPB = 3;
    localparam int B_T1_CMPA = 4;
    localparam int B_T1_CAP  = 5;
    localparam int B_T2_OVF  = 6;
    localparam int B_T2_CMP  = 7;

    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_FLAG = 1'b1;

    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] mask;
    } tirq_state_t;
endpackage

// File: rtl/tirq_evt_sync.sv
module tirq_evt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         tclk,
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] pulse_o
);
    localparam int CHAIN = STAGES + 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic             tog_d, tog_q;
        logic [CHAIN-1:0] chain_d, chain_q;

        always_comb begin
            tog_d = tog_q ^ evt_i[b];
        end

        always_ff @(posedge tclk or negedge rst_n) begin
            if (!rst_n) tog_q <= 1'b0;
            else        tog_q <= tog_d;
        end

        always_comb begin
            chain_d = {chain_q[CHAIN-2:0], tog_q};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign pulse_o[b] = chain_q[STAGES-1] ^ chain_q[STAGES];
    end
endmodule

// File: rtl/tirq_regs.sv
module tirq_regs
    import tirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] ack_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] mask_o
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] mask;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = ack_i;
        if (wr_en_i && (wr_sel_i == SEL_FLAG)) clr = clr | wr_data_i;
        if (wr_en_i && (wr_sel_i == SEL_MASK)) st_d.mask = wr_data_i;
        st_d.flag = (st_q.flag & ~clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/tirq_gate.sv
module tirq_gate #(
    parameter int N = 8
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] mask_i,
    input  logic         gie_i,
    output logic [N-1:0] irq_o
);
    always_comb begin
        irq_o = flag_i & mask_i & {N{gie_i}};
    end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tclk,
    input  logic [NASYNC-1:0] tev_i,
    input  logic [NSYNC-1:0]  sev_i,
    input  logic [NSRC-1:0]   ack_i,
    input  logic              gie_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [NSRC-1:0]   wr_data_i,
    input  logic              rd_sel_i,
    output logic [NSRC-1:0]   rd_data_o,
    output logic [NSRC-1:0]   irq_o
);
    logic [NASYNC-1:0] tev_sync;
    logic [NSRC-1:0]   set_vec;
    logic [NSRC-1:0]   flag_w;
    logic [NSRC-1:0]   mask_w;

    tirq_evt_sync #(.W(NASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .tclk    (tclk),
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (tev_i),
        .pulse_o (tev_sync)
    );

    assign set_vec = {tev_sync, sev_i};

    tirq_regs #(.N(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .ack_i     (ack_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .flag_o    (flag_w),
        .mask_o    (mask_w)
    );

    tirq_gate #(.N(NSRC)) u_gate (
        .flag_i (flag_w),
        .mask_i (mask_w),
        .gie_i  (gie_i),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_data_o = (rd_sel_i == SEL_FLAG) ? flag_w : mask_w;
    end
endmodule

// File: rtl/tmr_irq_unit_chk.sv
module tmr_irq_unit_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] set_vec,
    input logic [N-1:0] ack_i,
    input logic         wr_en_i,
    input logic         wr_sel_i,
    input logic [N-1:0] wr_data_i,
    input logic [N-1:0] flag_w,
    input logic [N-1:0] mask_w,
    input logic [N-1:0] irq_o,
    input logic         gie_i
);
    logic [N-1:0] clr_req;
    assign clr_req = ack_i | ((wr_en_i && wr_sel_i) ? wr_data_i : '0);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flag_w & $past(set_vec)) == $past(set_vec))); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_req & ~set_vec) != '0) |=> ((flag_w & $past(clr_req & ~set_vec)) == '0)); // R4

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec | clr_req) == '0) |=> $stable(flag_w)); // R5

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (mask_w == $past(wr_data_i))); // R7

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && !wr_sel_i) |=> $stable(mask_w)); // R7

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> gie_i); // R3
endmodule

bind tmr_irq_unit tmr_irq_unit_chk #(.N(tirq_pkg::NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .ack_i     (ack_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .flag_w    (flag_w),
    .mask_w    (mask_w),
    .irq_o     (irq_o),
    .gie_i     (gie_i)
);

// File: tb/tmr_irq_unit_bench.sv
module tmr_irq_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tclk = 1'b0;
    logic [1:0] tev_i = '0;
    logic [5:0] sev_i = '0;
    logic [7:0] ack_i = '0;
    logic       gie_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_sel_i = 1'b1;
    logic [7:0] rd_data_o;
    logic [7:0] irq_o;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_irq_unit u_tmr_irq_unit (
        .clk(clk), .rst_n(rst_n), .tclk(tclk), .tev_i(tev_i), .sev_i(sev_i),
        .ack_i(ack_i), .gie_i(gie_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic [5:0] sev;
        logic [7:0] ack;
        logic       we;
        logic       wsel;
        logic [7:0] wdata;
        logic       gie;
        logic [7:0] eflag;
        logic [7:0] eirq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{6'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b1, 8'h00, 8'h00}, // R7 enable all
        '{6'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 8'h01}, // R2 R3 t0 ovf
        '{6'h22, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h23, 8'h23}, // R2 capture + t0 cmp
        '{6'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h23, 8'h00}, // R3 gie low
        '{6'h00, 8'h00, 1'b1, 1'b1, 8'h02, 1'b1, 8'h21, 8'h21}, // R4 write-one clear
        '{6'h00, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 8'h20, 8'h20}, // R5 ack clear
        '{6'h01, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 8'h21, 8'h21}, // R6 set beats ack
        '{6'h04, 8'h00, 1'b1, 1'b1, 8'h04, 1'b1, 8'h25, 8'h25}, // R6 set beats write
        '{6'h00, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 8'h25, 8'h25}, // R4 zero write keeps
        '{6'h00, 8'h00, 1'b1, 1'b0, 8'h05, 1'b1, 8'h25, 8'h05}, // R7 R3 partial mask
        '{6'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 8'h00, 8'h00}, // R4 clear all
        '{6'h3F, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h3F, 8'h05}  // R2 all sync sources
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sev_i = '0; ack_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic tpulse(input logic [1:0] which);
        @(negedge clk);
        tev_i = which;
        #1 tclk = 1'b1;
        #1 tclk = 1'b0;
        tev_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_sel_i = 1'b1; #1 check("R1 pending", rd_data_o, 8'h00);
        rd_sel_i = 1'b0; #1 check("R1 enable", rd_data_o, 8'h00);
        check("R1 irq", irq_o, 8'h00);
        rd_sel_i = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sev_i = VEC[i].sev; ack_i = VEC[i].ack; wr_en_i = VEC[i].we;
            wr_sel_i = VEC[i].wsel; wr_data_i = VEC[i].wdata; gie_i = VEC[i].gie;
            @(posedge clk);
            #1;
            check($sformatf("R4 R5 R6 vec%0d pending", i), rd_data_o, VEC[i].eflag);
            check($sformatf("R3 vec%0d irq", i), irq_o, VEC[i].eirq);
        end
        idle_inputs();

        // R8: read enable then pending, twice, no change
        @(negedge clk);
        rd_sel_i = 1'b0; #1 check("R8 enable read", rd_data_o, 8'h05);
        rd_sel_i = 1'b1; #1 check("R8 pending read", rd_data_o, 8'h3F);
        @(negedge clk);
        check("R8 pending after read", rd_data_o, 8'h3F);

        // R9: async latency
        write_reg(1'b0, 8'hC0);
        write_reg(1'b1, 8'hFF);
        tpulse(2'b01);
        @(posedge clk); @(posedge clk); #1;
        check("R9 not yet after 2 edges", rd_data_o & 8'hC0, 8'h00);
        @(posedge clk); #1;
        check("R9 set after 3 edges", rd_data_o & 8'hC0, 8'h40);
        check("R9 irq async ovf", irq_o, 8'h40);

        // R10: repeated async pulses on compare source
        write_reg(1'b1, 8'hFF);
        tpulse(2'b10);
        repeat (4) @(posedge clk); #1;
        check("R10 first pulse", rd_data_o, 8'h80);
        write_reg(1'b1, 8'h80);
        check("R10 cleared", rd_data_o, 8'h00);
        tpulse(2'b10);
        repeat (4) @(posedge clk); #1;
        check("R10 second pulse", rd_data_o, 8'h80);
        tpulse(2'b10);
        repeat (4) @(posedge clk); #1;
        check("R10 third pulse keeps set", rd_data_o, 8'h80);

        // R5 ack on async bit
        @(negedge clk); ack_i = 8'h80;
        @(posedge clk); #1;
        check("R5 ack async bit", rd_data_o, 8'h00);
        idle_inputs();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule